// File: doc/BRIEF.md
# Translation Lookaside Cache with Global-Entry Retention

This block is a small fully associative cache of address translations. Each entry pairs a 20-bit virtual page number with a 20-bit physical frame number for 4 KB pages. Each entry also keeps five flags taken from the page table entry that produced it. A lookup presents a virtual page number. The next cycle brings a registered hit indication, the frame number and the flags. A fill installs the entry that a page walk returned; the walker and all permission checks sit outside this block.

Two invalidation inputs keep the cache coherent with the tables in memory. A write to the translation root register drops every entry except those whose global flag is set. A single-page invalidate drops the one entry that matches its virtual page, global or not. When the cache is full, replacement uses a round-robin pointer. Free slots are always used before any resident entry is evicted.

Top module: `xlat_cache`

## Requirements
- R1: A lookup with `lk_en` high at a clock edge sets `lk_hit`, `lk_pfn` and `lk_flags` at that same edge, so they are seen one cycle later. `lk_hit` is 1 only when a valid entry holds `lk_vpn`, and it is 0 in any cycle after `lk_en` was low.
- R2: After reset no entry is valid and `lk_hit` is 0.
- R3: A cycle with `root_wr` high invalidates every entry whose global flag is 0 and leaves entries whose global flag is 1 resident.
- R4: A cycle with `inv_en` high removes the entry holding `inv_vpn`, even when it is global, and leaves every other entry resident and unchanged.
- R5: A fill stores `fill_pte[31:12]` as the frame. On a hit, `lk_flags` is {global=`fill_pte[8]`, dirty=`fill_pte[6]`, user=`fill_pte[2]`, write=`fill_pte[1]`, present=`fill_pte[0]`}, most significant bit first. PTE bits 3, 4, 5, 7 and 9 to 11 have no effect on any output.
- R6: A fill whose virtual page is already resident overwrites that entry in place, so no second copy is created and no other entry is displaced.
- R7: A fill of a new page takes the lowest-indexed free entry. When no entry is free, it evicts the entry at a round-robin pointer that starts at 0 after reset and advances by one on each eviction.
- R8: A lookup in the same cycle as a root write or an invalidate reports the contents from before that invalidation.
- R9: When a fill coincides with a root write or an invalidate, the invalidation is applied first and the fill is written afterwards, so the new entry stays resident even when it is not global.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_en | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to look up |
| lk_hit | output | 1 | Registered lookup hit |
| lk_pfn | output | 20 | Registered frame number on a hit |
| lk_flags | output | 5 | Registered flags {global, dirty, user, write, present} |
| fill_en | input | 1 | Install an entry |
| fill_vpn | input | 20 | Virtual page of the new entry |
| fill_pte | input | 32 | Page table entry word for the new entry |
| root_wr | input | 1 | Root register write: flush all non-global entries |
| inv_en | input | 1 | Single-page invalidate request |
| inv_vpn | input | 20 | Virtual page to invalidate |

## Verification
The assertions assume the reset is held for at least one clock edge before any request is made. They also assume that every fill names a virtual page that is either resident or new, so the duplicate-free property depends only on the block itself. The one-entry-per-cycle growth bound assumes at most one fill per cycle, which the single fill port already enforces. The stimulus comes from one task that drives every input for exactly one cycle. A reference model in the bench predicts each result from the requirements; it applies invalidations before fills and keeps its own copy of the round-robin pointer.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VPN_W = 20;
  localparam int PFN_W = 20;
  localparam int PTE_W = 32;

  typedef struct packed {
    logic glb;
    logic dirty;
    logic user;
    logic write;
    logic present;
  } xlat_flags_t;

  function automatic xlat_flags_t pte_flags(input logic [PTE_W-1:0] pte);
    xlat_flags_t f;
    f.glb     = pte[8];
    f.dirty   = pte[6];
    f.user    = pte[2];
    f.write   = pte[1];
    f.present = pte[0];
    return f;
  endfunction
endpackage

// File: rtl/xlat_tag_cam.sv
module xlat_tag_cam #(
  parameter int N = 8,
  parameter int W = 20
) (
  input  logic [N-1:0][W-1:0] tags,
  input  logic [N-1:0]        valid,
  input  logic [W-1:0]        key,
  output logic [N-1:0]        hit_vec
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = valid[i] && (tags[i] == key);
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fill_en,
  input  logic [N-1:0]  resident_hit,
  input  logic [N-1:0]  free_after,
  output logic [IW-1:0] slot
);
  logic [IW-1:0] rr_q;
  logic [IW-1:0] hit_idx, free_idx;
  logic          any_hit, any_free;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    any_hit  = 1'b0;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (resident_hit[i]) begin
        hit_idx = IW'(i);
        any_hit = 1'b1;
      end
      if (free_after[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
    end
    if (any_hit)       slot = hit_idx;
    else if (any_free) slot = free_idx;
    else               slot = rr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (fill_en && !any_hit && !any_free) begin
      rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  a_r7_pointer_range: assert property (@(posedge clk) disable iff (rst)
    int'(rr_q) < N);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_en,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic [4:0]       lk_flags,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PTE_W-1:0] fill_pte,
  input  logic             root_wr,
  input  logic             inv_en,
  input  logic [VPN_W-1:0] inv_vpn
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0][VPN_W-1:0] tag_q;
  logic [N-1:0][PFN_W-1:0] pfn_q;
  xlat_flags_t [N-1:0]     flg_q;
  logic [N-1:0]            vld_q;

  logic [N-1:0] lk_vec, inv_vec, fill_vec, glb_vec, clr_vec, vld_after;
  logic [IW-1:0] slot;
  logic [PFN_W-1:0] rd_pfn;
  xlat_flags_t rd_flg;

  xlat_tag_cam #(.N(N), .W(VPN_W)) i_cam_lk (
    .tags(tag_q), .valid(vld_q), .key(lk_vpn), .hit_vec(lk_vec));
  xlat_tag_cam #(.N(N), .W(VPN_W)) i_cam_inv (
    .tags(tag_q), .valid(vld_q), .key(inv_vpn), .hit_vec(inv_vec));
  xlat_tag_cam #(.N(N), .W(VPN_W)) i_cam_fill (
    .tags(tag_q), .valid(vld_q), .key(fill_vpn), .hit_vec(fill_vec));

  for (genvar i = 0; i < N; i++) begin : g_glb
    assign glb_vec[i] = flg_q[i].glb;
  end

  assign clr_vec   = (root_wr ? ~glb_vec : '0) | (inv_en ? inv_vec : '0);
  assign vld_after = vld_q & ~clr_vec;

  xlat_victim #(.N(N)) i_victim (
    .clk(clk), .rst(rst), .fill_en(fill_en),
    .resident_hit(fill_vec), .free_after(~vld_after), .slot(slot));

  always_comb begin
    rd_pfn = '0;
    rd_flg = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_vec[i]) begin
        rd_pfn = rd_pfn | pfn_q[i];
        rd_flg = rd_flg | flg_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      lk_hit   <= 1'b0;
      lk_pfn   <= '0;
      lk_flags <= '0;
    end else begin
      vld_q    <= vld_after | (fill_en ? (N'(1) << slot) : '0);
      lk_hit   <= lk_en && (lk_vec != '0);
      lk_pfn   <= rd_pfn;
      lk_flags <= rd_flg;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[slot] <= fill_vpn;
      pfn_q[slot] <= fill_pte[PTE_W-1:12];
      flg_q[slot] <= pte_flags(fill_pte);
    end
  end

  // R6: a page is never resident twice
  a_r6_no_duplicate: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_vec));
  // R3: after a root write without fill, nothing non-global is left
  a_r3_flush_nonglobal: assert property (@(posedge clk) disable iff (rst)
    root_wr && !fill_en |=> (vld_q & ~glb_vec) == '0);
  // R1: a hit is only reported after a lookup request
  a_r1_hit_needs_lookup: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> $past(lk_en));
  // R7: at most one entry becomes valid per cycle
  a_r7_one_install: assert property (@(posedge clk) disable iff (rst)
    $countones(vld_q) <= $countones($past(vld_q)) + 1);
endmodule

// File: tb/test_xlat_cache.sv
module test_xlat_cache;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst;
  logic lk_en, fill_en, root_wr, inv_en;
  logic [19:0] lk_vpn, fill_vpn, inv_vpn;
  logic [31:0] fill_pte;
  logic lk_hit;
  logic [19:0] lk_pfn;
  logic [4:0] lk_flags;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  bit        m_v[N];
  logic [19:0] m_tag[N];
  logic [19:0] m_pfn[N];
  logic [4:0]  m_flg[N];
  int        m_rr;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_cache #(.N(N)) i_xlat_cache (
    .clk(clk), .rst(rst), .lk_en(lk_en), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
    .lk_pfn(lk_pfn), .lk_flags(lk_flags), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_pte(fill_pte), .root_wr(root_wr),
    .inv_en(inv_en), .inv_vpn(inv_vpn));

  function automatic logic [19:0] vpn_of(int i);
    return 20'h12340 + 20'(i * 37);
  endfunction

  function automatic logic [4:0] flags_of(logic [31:0] p);
    return {p[8], p[6], p[2], p[1], p[0]};
  endfunction

  task automatic cyc(string req, bit l, logic [19:0] lv, bit f, logic [19:0] fv,
                     logic [31:0] fp, bit rw, bit ie, logic [19:0] iv);
    bit e_hit = 0;
    logic [19:0] e_pfn = '0;
    logic [4:0]  e_flg = '0;
    bool_upd: begin end
    lk_en = l; lk_vpn = lv; fill_en = f; fill_vpn = fv; fill_pte = fp;
    root_wr = rw; inv_en = ie; inv_vpn = iv;
    for (int i = 0; i < N; i++)
      if (l && m_v[i] && m_tag[i] == lv) begin
        e_hit = 1; e_pfn = m_pfn[i]; e_flg = m_flg[i];
      end
    @(posedge clk);
    begin
      int slot = -1;
      bit pre[N];
      for (int i = 0; i < N; i++) pre[i] = m_v[i];
      for (int i = 0; i < N; i++) begin
        if (rw && !m_flg[i][4]) m_v[i] = 0;
        if (ie && m_tag[i] == iv) m_v[i] = 0;
      end
      if (f) begin
        for (int i = N - 1; i >= 0; i--) if (pre[i] && m_tag[i] == fv) slot = i;
        if (slot < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
        if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % N; end
        m_v[slot] = 1; m_tag[slot] = fv; m_pfn[slot] = fp[31:12];
        m_flg[slot] = flags_of(fp);
      end
    end
    @(negedge clk);
    lk_en = 0; fill_en = 0; root_wr = 0; inv_en = 0;
    if (l) begin
      vectors++;
      if (lk_hit !== e_hit || (e_hit && (lk_pfn !== e_pfn || lk_flags !== e_flg))) begin
        fails++;
        $display("FAIL %s vpn=%h: hit/pfn/flags %b/%h/%b expected %b/%h/%b",
                 req, lv, lk_hit, lk_pfn, lk_flags, e_hit, e_pfn, e_flg);
      end
    end
  endtask

  task automatic look(string req, logic [19:0] v);
    cyc(req, 1, v, 0, '0, '0, 0, 0, '0);
  endtask

  task automatic fill(logic [19:0] v, logic [31:0] p);
    cyc("R7", 0, '0, 1, v, p, 0, 0, '0);
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < 14; i++) look(req, vpn_of(i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    lk_en = 0; fill_en = 0; root_wr = 0; inv_en = 0;
    lk_vpn = '0; fill_vpn = '0; inv_vpn = '0; fill_pte = '0;
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_tag[i] = '0; m_pfn[i] = '0; m_flg[i] = '0; end
    m_rr = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    vectors++;
    if (lk_hit !== 1'b0) begin
      fails++; $display("FAIL R2 reset lk_hit %b expected 0", lk_hit);
    end
    sweep("R2");
    // R5: fill with flag patterns, including ignored bits set
    for (int i = 0; i < N; i++)
      fill(vpn_of(i), {20'hA0000 + 20'(i), 12'(((i % 2) << 8) | (i * 11)) | 12'hEB8});
    sweep("R5");
    look("R1", vpn_of(0));
    cyc("R1", 0, vpn_of(1), 0, '0, '0, 0, 0, '0);
    if (lk_hit !== 1'b0) begin
      fails++; $display("FAIL R1 idle lk_hit %b expected 0", lk_hit);
    end
    vectors++;
    // R7: cache full, two evictions via round robin
    fill(vpn_of(8), 32'hB0008_001);
    fill(vpn_of(9), 32'hB0009_103);
    sweep("R7");
    // R6: refill a resident page in place
    fill(vpn_of(4), 32'hC0004_147);
    sweep("R6");
    // R8: lookup sees state before flush / invalidate
    cyc("R8", 1, vpn_of(2), 0, '0, '0, 1, 0, '0);
    sweep("R3");
    cyc("R8", 1, vpn_of(9), 0, '0, '0, 0, 1, vpn_of(9));
    sweep("R4");
    // R4: invalidate of a global entry
    cyc("R4", 0, '0, 0, '0, '0, 0, 1, vpn_of(4));
    sweep("R4");
    // R9: fill together with flush and with invalidate
    cyc("R9", 0, '0, 1, vpn_of(10), 32'hD000A_003, 1, 0, '0);
    cyc("R9", 0, '0, 1, vpn_of(11), 32'hD000B_001, 0, 1, vpn_of(10));
    sweep("R9");
    // R7: refill to full and wrap the pointer several times
    for (int k = 0; k < 20; k++) fill(20'h50000 + 20'(k), {20'hE0000 + 20'(k), 12'h003});
    for (int k = 0; k < 20; k++) look("R7", 20'h50000 + 20'(k));
    sweep("R7");
    // R3: full flush then sweep
    cyc("R3", 0, '0, 0, '0, '0, 1, 0, '0);
    for (int k = 0; k < 20; k++) look("R3", 20'h50000 + 20'(k));
    sweep("R3");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule